// File: doc/BRIEF.md
# Debug Data-Bus Scan Chain

This block is a 67-cell serial test data register. It sits between a processor core's instruction input, its bidirectional data bus and three control cells. A JTAG TAP controller, which is outside the block, drives it with single-cycle capture, shift and update strobes and with a select line. The block shifts serial data from `tdi` toward `tdo`. It loads parallel values into the chain on capture. On update it copies the chain into holding registers that feed the core and the data-bus pads.

The block serves three test modes:
- **Internal test:** the core's instruction word and its bus-enable signal are sampled into the chain.
- **External test:** a bus-enable cell chooses one of two actions. Either the data-bus cells drive the pads, or they sample the pad values.
- **Debug:** a debugger scans in an instruction and a system-speed flag. The core executes the instruction, resynchronising to system speed first if the flag asks for it.

After the core enters debug state, the block reports the entry cause. The first capture of the system-speed cell gives the cause. A second control cell tells a debugger whether a watchpoint coincided with a breakpointed instruction in the execute stage.

Chain bits are numbered 1 to 67, with bit 1 nearest `tdo`:
- Bits 1 to 32 hold instruction bits 0 to 31.
- Bit 33 is the system-speed cell.
- Bit 34 is the watchpoint-and-breakpoint cell.
- Bit 35 is the bus-enable cell.
- Bits 36 to 67 hold the data bus in reversed order: bit 36 is data bit 31 and bit 67 is data bit 0.

Top module: `dbus_scan_chain`

## Requirements
- R1: After reset, `tdo`, `instr_out`, `sysspd_out`, `dbus_out` and `dbus_oe` are all 0, and every chain cell reads 0.
- R2: While `sel` is high and `shift_en` is high with no capture, each clock moves the chain one cell toward `tdo`. `tdi` enters at bit 67 and `tdo` shows bit 1, so 67 shifts return the previously held contents, bit 1 first.
- R3: `instr_out`, `sysspd_out` and `dbus_out` change only on a clock where `sel` and `upd_en` are both high. Then `instr_out[k]` takes chain bit k+1.
- R4: The data-bus cells are reversed: `dbus_out[i]` is loaded from chain bit 67−i, and a capture places pad bit i in chain bit 67−i.
- R5: `dbus_oe` is high exactly when `ext_test` is high and the updated bus-enable value (from chain bit 35) is 1. In that case `dbus_out` carries the updated data cells.
- R6: During a capture with `ext_test` high, the data cells behave in one of two ways. If the updated bus-enable value is 0, they load `dbus_pin`. If it is 1, they keep their contents.
- R7: During a capture with `ext_test` low, bits 32..1 load `core_instr`, bit 35 loads `core_den`, and the data cells load `dbus_pin`.
- R8: `sysspd_out` takes chain bit 33 on update.
- R9: The first selected capture after a `dbg_enter` pulse loads bit 33 with the entry cause: 0 for a breakpoint, 1 for a watchpoint (`dbg_wpt`). Later captures load the current `sysspd_out`.
- R10: On capture, bit 34 loads the value of `dbg_wpt AND dbg_ex_bkpt` held at the latest `dbg_enter`.
- R11: Strobes given while `sel` is low leave the chain, the holding registers and the debug-entry tracking unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | This chain is selected |
| cap_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| upd_en | input | 1 | Update strobe |
| ext_test | input | 1 | External-test instruction active |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (chain bit 1) |
| core_instr | input | 32 | Instruction word seen by the core |
| core_den | input | 1 | Core data-bus enable |
| dbus_pin | input | 32 | Data-bus pad values |
| dbg_enter | input | 1 | Debug-entry pulse |
| dbg_wpt | input | 1 | Entry cause is a watchpoint |
| dbg_ex_bkpt | input | 1 | Execute-stage instruction is breakpointed |
| instr_out | output | 32 | Instruction presented to the core |
| sysspd_out | output | 1 | Resync-to-system-speed request |
| dbus_out | output | 32 | Data-bus drive values |
| dbus_oe | output | 1 | Data-bus pad drive enable |

## Verification
- **Data-bus bit order.** Patterns with distinct halves are pushed through the pads and the chain. A design that stored the data bus unreversed would show a bit-swapped `dbus_out` and a mirrored readback.
- **Bus-enable cell in external test.** Both settings are tested. A design that ignored the cell would drive with a 0 scanned in, or would overwrite driven data with pad values on capture.
- **Entry-cause flag.** Captures are repeated after each debug entry. A design that never cleared the sticky flag would keep reporting the cause instead of the live speed bit. One that never set it would miss the cause.
- **Strobes while deselected.** These must leave every output and the scanned contents unchanged. A design that ignored `sel` would corrupt them.

// File: rtl/dbsc_pkg.sv
package dbsc_pkg;
  localparam int unsigned NUM_CTRL = 3;
  // control cell positions relative to the end of the instruction field
  localparam int unsigned OFS_SPD  = 0;
  localparam int unsigned OFS_WB   = 1;
  localparam int unsigned OFS_DEN  = 2;

  function automatic int unsigned chain_len(input int unsigned iw, input int unsigned dw);
    return iw + NUM_CTRL + dw;
  endfunction

  typedef struct packed {
    logic spd;
    logic wb;
    logic den;
  } ctrl_cells_t;
endpackage

// File: rtl/dbsc_cause_track.sv
module dbsc_cause_track (
  input  logic clk,
  input  logic rst_n,
  input  logic enter,
  input  logic wpt,
  input  logic ex_bkpt,
  input  logic cap_fire,
  output logic pending,
  output logic cause_wpt,
  output logic both_hit
);
  logic pending_d, cause_d, both_d;

  always_comb begin
    pending_d = pending;
    cause_d   = cause_wpt;
    both_d    = both_hit;
    if (enter) begin
      pending_d = 1'b1;
      cause_d   = wpt;
      both_d    = wpt & ex_bkpt;
    end else if (cap_fire) begin
      pending_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      cause_wpt <= 1'b0;
      both_hit  <= 1'b0;
    end else begin
      pending   <= pending_d;
      cause_wpt <= cause_d;
      both_hit  <= both_d;
    end
  end
endmodule

// File: rtl/dbsc_chain.sv
module dbsc_chain #(
  parameter int unsigned IW = 32,
  parameter int unsigned DW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_fire,
  input  logic                shift_fire,
  input  logic                tdi,
  input  logic [IW-1:0]       cap_instr,
  input  logic                cap_instr_en,
  input  dbsc_pkg::ctrl_cells_t cap_ctrl,
  input  logic                cap_den_en,
  input  logic [DW-1:0]       cap_data,   // chain order
  input  logic                cap_data_en,
  output logic [dbsc_pkg::chain_len(IW, DW)-1:0] chain_q
);
  localparam int unsigned L     = dbsc_pkg::chain_len(IW, DW);
  localparam int unsigned P_SPD = IW + dbsc_pkg::OFS_SPD;
  localparam int unsigned P_WB  = IW + dbsc_pkg::OFS_WB;
  localparam int unsigned P_DEN = IW + dbsc_pkg::OFS_DEN;
  localparam int unsigned P_DAT = IW + dbsc_pkg::NUM_CTRL;

  logic [L-1:0] chain_d;

  always_comb begin
    chain_d = chain_q;
    if (cap_fire) begin
      if (cap_instr_en) chain_d[IW-1:0] = cap_instr;
      chain_d[P_SPD] = cap_ctrl.spd;
      chain_d[P_WB]  = cap_ctrl.wb;
      if (cap_den_en)  chain_d[P_DEN] = cap_ctrl.den;
      if (cap_data_en) chain_d[L-1:P_DAT] = cap_data;
    end else if (shift_fire) begin
      chain_d = {tdi, chain_q[L-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end
endmodule

// File: rtl/dbsc_update.sv
module dbsc_update #(
  parameter int unsigned IW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_fire,
  input  logic [IW-1:0] in_instr,
  input  logic          in_spd,
  input  logic          in_den,
  input  logic [DW-1:0] in_data,
  output logic [IW-1:0] instr_q,
  output logic          spd_q,
  output logic          den_q,
  output logic [DW-1:0] data_q
);
  logic [IW-1:0] instr_d;
  logic          spd_d, den_d;
  logic [DW-1:0] data_d;

  always_comb begin
    instr_d = instr_q;
    spd_d   = spd_q;
    den_d   = den_q;
    data_d  = data_q;
    if (upd_fire) begin
      instr_d = in_instr;
      spd_d   = in_spd;
      den_d   = in_den;
      data_d  = in_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      instr_q <= '0;
      spd_q   <= 1'b0;
      den_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      instr_q <= instr_d;
      spd_q   <= spd_d;
      den_q   <= den_d;
      data_q  <= data_d;
    end
  end
endmodule

// File: rtl/dbus_scan_chain.sv
module dbus_scan_chain #(
  parameter int unsigned IW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          cap_en,
  input  logic          shift_en,
  input  logic          upd_en,
  input  logic          ext_test,
  input  logic          tdi,
  output logic          tdo,
  input  logic [IW-1:0] core_instr,
  input  logic          core_den,
  input  logic [DW-1:0] dbus_pin,
  input  logic          dbg_enter,
  input  logic          dbg_wpt,
  input  logic          dbg_ex_bkpt,
  output logic [IW-1:0] instr_out,
  output logic          sysspd_out,
  output logic [DW-1:0] dbus_out,
  output logic          dbus_oe
);
  localparam int unsigned L     = dbsc_pkg::chain_len(IW, DW);
  localparam int unsigned P_SPD = IW + dbsc_pkg::OFS_SPD;
  localparam int unsigned P_DEN = IW + dbsc_pkg::OFS_DEN;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic cap_fire, shift_fire, upd_fire;
  assign cap_fire   = sel & cap_en;
  assign shift_fire = sel & shift_en & ~cap_en;
  assign upd_fire   = sel & upd_en;

  logic pending, cause_wpt, both_hit;
  dbsc_cause_track u_cause (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .enter    (dbg_enter),
    .wpt      (dbg_wpt),
    .ex_bkpt  (dbg_ex_bkpt),
    .cap_fire (cap_fire),
    .pending  (pending),
    .cause_wpt(cause_wpt),
    .both_hit (both_hit)
  );

  logic [L-1:0]  chain_q;
  logic [DW-1:0] pin_chain_ord;
  logic [DW-1:0] chain_bus_ord;
  logic          den_q;
  logic [DW-1:0] data_q;

  // data cells are stored in reversed bus order
  for (genvar i = 0; i < DW; i++) begin : g_rev
    assign pin_chain_ord[i] = dbus_pin[DW-1-i];
    assign chain_bus_ord[i] = chain_q[L-1-i];
  end

  dbsc_pkg::ctrl_cells_t cap_ctrl;
  always_comb begin
    cap_ctrl.spd = pending ? cause_wpt : sysspd_out;
    cap_ctrl.wb  = both_hit;
    cap_ctrl.den = core_den;
  end

  logic data_cap_en;
  assign data_cap_en = ~(ext_test & den_q);

  dbsc_chain #(.IW(IW), .DW(DW)) u_chain (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cap_fire    (cap_fire),
    .shift_fire  (shift_fire),
    .tdi         (tdi),
    .cap_instr   (core_instr),
    .cap_instr_en(~ext_test),
    .cap_ctrl    (cap_ctrl),
    .cap_den_en  (~ext_test),
    .cap_data    (pin_chain_ord),
    .cap_data_en (data_cap_en),
    .chain_q     (chain_q)
  );

  dbsc_update #(.IW(IW), .DW(DW)) u_upd (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .upd_fire(upd_fire),
    .in_instr(chain_q[IW-1:0]),
    .in_spd  (chain_q[P_SPD]),
    .in_den  (chain_q[P_DEN]),
    .in_data (chain_bus_ord),
    .instr_q (instr_out),
    .spd_q   (sysspd_out),
    .den_q   (den_q),
    .data_q  (data_q)
  );

  assign tdo      = chain_q[0];
  assign dbus_out = data_q;
  assign dbus_oe  = ext_test & den_q;
endmodule

// File: rtl/dbus_scan_chain_chk.sv
module dbus_scan_chain_chk #(
  parameter int unsigned IW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned L  = 67
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel,
  input logic          cap_en,
  input logic          shift_en,
  input logic          upd_en,
  input logic          ext_test,
  input logic          tdo,
  input logic [IW-1:0] instr_out,
  input logic          sysspd_out,
  input logic [DW-1:0] dbus_out,
  input logic          dbus_oe,
  input logic [L-1:0]  chain_q
);
  // R3 / R8: holding registers move only on a selected update
  a_r3_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && upd_en) |=> ($stable(instr_out) && $stable(sysspd_out)));

  // R11: without a selected capture or shift, tdo keeps its value
  a_r11_tdo_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && (cap_en || shift_en)) |=> $stable(tdo));

  // R2: a selected shift brings the next cell to tdo
  a_r2_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && shift_en && !cap_en) |=> (tdo == $past(chain_q[1])));

  // R5: no pad drive outside external test
  a_r5_oe_ext_only: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_test |-> !dbus_oe);

  // R4 / R5: driven bus values follow update only
  a_r4_dbus_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && upd_en) |=> $stable(dbus_out));
endmodule

bind dbus_scan_chain dbus_scan_chain_chk #(.IW(IW), .DW(DW), .L(L)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel       (sel),
  .cap_en    (cap_en),
  .shift_en  (shift_en),
  .upd_en    (upd_en),
  .ext_test  (ext_test),
  .tdo       (tdo),
  .instr_out (instr_out),
  .sysspd_out(sysspd_out),
  .dbus_out  (dbus_out),
  .dbus_oe   (dbus_oe),
  .chain_q   (chain_q)
);

// File: tb/dbus_scan_chain_tb.sv
module dbus_scan_chain_tb;
  logic        clk = 1'b0;
  logic        rst_n, sel, cap_en, shift_en, upd_en, ext_test, tdi;
  logic        tdo, core_den, dbg_enter, dbg_wpt, dbg_ex_bkpt;
  logic [31:0] core_instr, dbus_pin, instr_out, dbus_out;
  logic        sysspd_out, dbus_oe;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  dbus_scan_chain u_dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .cap_en(cap_en), .shift_en(shift_en),
    .upd_en(upd_en), .ext_test(ext_test), .tdi(tdi), .tdo(tdo),
    .core_instr(core_instr), .core_den(core_den), .dbus_pin(dbus_pin),
    .dbg_enter(dbg_enter), .dbg_wpt(dbg_wpt), .dbg_ex_bkpt(dbg_ex_bkpt),
    .instr_out(instr_out), .sysspd_out(sysspd_out), .dbus_out(dbus_out),
    .dbus_oe(dbus_oe)
  );

  // chain image from the requirement layout (index 0 = bit 1)
  function automatic logic [66:0] mk(logic [31:0] ins, logic ss, logic wb,
                                     logic den, logic [31:0] d);
    logic [66:0] v;
    v[31:0] = ins;
    v[32] = ss;
    v[33] = wb;
    v[34] = den;
    for (int j = 0; j < 32; j++) v[35+j] = d[31-j];
    return v;
  endfunction

  task automatic chk(string req, logic [66:0] act, logic [66:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic scan(input logic [66:0] din, output logic [66:0] dout);
    for (int i = 0; i < 67; i++) begin
      tdi      = din[i];
      dout[i]  = tdo;
      shift_en = 1'b1;
      @(negedge clk);
      shift_en = 1'b0;
    end
  endtask

  task automatic pulse_cap();
    cap_en = 1'b1; @(negedge clk); cap_en = 1'b0;
  endtask

  task automatic pulse_upd();
    upd_en = 1'b1; @(negedge clk); upd_en = 1'b0;
  endtask

  task automatic enter_dbg(logic w, logic b);
    dbg_wpt = w; dbg_ex_bkpt = b; dbg_enter = 1'b1;
    @(negedge clk);
    dbg_enter = 1'b0;
  endtask

  task automatic t_reset();
    logic [66:0] rb;
    chk("R1 outputs", {tdo, sysspd_out, dbus_oe, instr_out, dbus_out}, '0);
    scan('0, rb);
    chk("R1 chain", rb, '0);
  endtask

  task automatic t_shift();
    logic [66:0] a, rb;
    a = mk(32'h0F1E2D3C, 1'b1, 1'b0, 1'b1, 32'h8001_7FFE);
    scan(a, rb);
    scan(~a, rb);
    chk("R2 passthrough", rb, a);
    // deselected strobes
    sel = 1'b0; tdi = 1'b1;
    shift_en = 1'b1; repeat (5) @(negedge clk); shift_en = 1'b0;
    core_instr = 32'hFFFF_FFFF; dbus_pin = 32'hFFFF_FFFF;
    pulse_cap();
    pulse_upd();
    chk("R11 outputs unchanged", {sysspd_out, instr_out, dbus_out}, '0);
    sel = 1'b1;
    scan('0, rb);
    chk("R11 chain unchanged", rb, ~a);
  endtask

  task automatic t_update();
    logic [66:0] rb;
    scan(mk(32'h1234_5678, 1'b1, 1'b0, 1'b0, 32'hA5A5_0F0F), rb);
    chk("R3 no change before update", {sysspd_out, instr_out, dbus_out}, '0);
    pulse_upd();
    chk("R3 instr_out", instr_out, 32'h1234_5678);
    chk("R8 sysspd_out", sysspd_out, 1'b1);
    chk("R4 dbus_out order", dbus_out, 32'hA5A5_0F0F);
    chk("R5 no drive in internal test", dbus_oe, 1'b0);
  endtask

  task automatic t_ext_drive();
    logic [66:0] rb, img;
    ext_test = 1'b1;
    img = mk(32'h0, 1'b1, 1'b0, 1'b1, 32'hCAFE_F00D);
    scan(img, rb);
    pulse_upd();
    chk("R5 drive enable", dbus_oe, 1'b1);
    chk("R5 drive value", dbus_out, 32'hCAFE_F00D);
    dbus_pin = 32'h1111_2222;
    pulse_cap();
    scan('0, rb);
    chk("R6 data kept while driving", rb[66:35], img[66:35]);
    chk("R7 bus-enable cell kept in external test", rb[34], 1'b1);
  endtask

  task automatic t_ext_sample();
    logic [66:0] rb;
    ext_test = 1'b1;
    scan(mk(32'h0, 1'b1, 1'b0, 1'b0, 32'h0), rb);
    pulse_upd();
    chk("R5 drive off with 0", dbus_oe, 1'b0);
    dbus_pin = 32'h3C3C_1234;
    pulse_cap();
    scan('0, rb);
    chk("R6 pad sample", rb[66:35], mk('0, 1'b0, 1'b0, 1'b0, 32'h3C3C_1234) >> 35);
    ext_test = 1'b0;
  endtask

  task automatic t_int_capture();
    logic [66:0] rb;
    ext_test = 1'b0;
    core_instr = 32'hDEAD_BEEF; core_den = 1'b1; dbus_pin = 32'h0000_FFFF;
    pulse_cap();
    scan('0, rb);
    chk("R7 instr capture", rb[31:0], 32'hDEAD_BEEF);
    chk("R7 den capture", rb[34], 1'b1);
    chk("R7 R4 data capture", rb[66:35], mk('0, 1'b0, 1'b0, 1'b0, 32'h0000_FFFF) >> 35);
  endtask

  task automatic t_cause();
    logic [66:0] rb;
    ext_test = 1'b0;
    // live speed bit = 0
    scan(mk('0, 1'b0, 1'b0, 1'b0, '0), rb);
    pulse_upd();
    enter_dbg(1'b1, 1'b1);
    pulse_cap(); scan('0, rb);
    chk("R9 watchpoint cause", rb[32], 1'b1);
    chk("R10 watch and break", rb[33], 1'b1);
    pulse_cap(); scan('0, rb);
    chk("R9 later capture live", rb[32], 1'b0);
    // live speed bit = 1
    scan(mk('0, 1'b1, 1'b0, 1'b0, '0), rb);
    pulse_upd();
    enter_dbg(1'b0, 1'b1);
    pulse_cap(); scan('0, rb);
    chk("R9 breakpoint cause", rb[32], 1'b0);
    chk("R10 break only", rb[33], 1'b0);
    pulse_cap(); scan('0, rb);
    chk("R9 later capture live 1", rb[32], 1'b1);
    enter_dbg(1'b1, 1'b0);
    // deselected capture must not consume the cause
    sel = 1'b0; pulse_cap(); sel = 1'b1;
    scan(mk('0, 1'b0, 1'b0, 1'b0, '0), rb);
    pulse_upd();
    pulse_cap(); scan('0, rb);
    chk("R11 R9 cause kept past deselected capture", rb[32], 1'b1);
    chk("R10 watch only", rb[33], 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; sel = 1'b1; cap_en = 1'b0; shift_en = 1'b0; upd_en = 1'b0;
    ext_test = 1'b0; tdi = 1'b0; core_instr = '0; core_den = 1'b0;
    dbus_pin = '0; dbg_enter = 1'b0; dbg_wpt = 1'b0; dbg_ex_bkpt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_shift();
    t_update();
    t_ext_drive();
    t_ext_sample();
    t_int_capture();
    t_cause();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 100000 && !done) begin
      tests++;
      fails++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule